// File: doc/BRIEF.md
# Framed Pseudorandom Word Serializer

The block produces a continuous serial test stream for an external ten-to-one deserializer. On every bit clock a 16-bit maximal-length shift-register generator yields one new pseudorandom bit, and the ten most recent bits are kept in a collector. Once every twelve bit clocks, at the word boundary, a payload is captured. It comes either from that collector or from one of two fixed test patterns. The payload is wrapped in a leading one and a trailing zero, and the resulting twelve-bit frame is shifted out one bit per clock.

Each bit leaves on two outputs. One carries the bit as framed and the other carries its inverse, ready for a differential driver. No line code or scrambling is applied. A one-cycle strobe marks the cycle in which each frame's first bit is on the line. The receiver recovers word alignment from the framing bits, strips them, and presents the ten payload bits.

Top module: `frame_serializer_top`

## Requirements
- R1: Every frame is 12 bits sent on consecutive cycles: a start bit of 1 first, then the 10 payload bits most-significant first, then a stop bit of 0 last, with no further encoding.
- R2: `wordStrobe` is high for exactly one cycle, in the cycle where the start bit is driven, and consecutive strobes are exactly 12 cycles apart.
- R3: `patSel` encoding: 2'b01 selects payload 0101010101 (frame on the wire 101010101010), 2'b10 selects payload 1111100000 (frame 111111000000), and 2'b00 or 2'b11 selects the pseudorandom payload.
- R4: The pseudorandom generator is a 16-bit register seeded to 16'hACE1 by reset. Each cycle its feedback bit is formed as the XOR of state bits 15, 13, 12 and 10. The register shifts left by one with the feedback bit entering bit 0. That same feedback bit also enters bit 0 of a 10-bit collector that shifts left every cycle and clears on reset. A random payload equals the collector contents at the boundary, so the oldest bit sits in the MSB.
- R5: The generator state is never all zeros outside reset.
- R6: `serInv` is always the logical inverse of `serTrue` outside reset.
- R7: `patSel` is sampled only at the word boundary. A change in the middle of a frame leaves the current frame unchanged and takes effect in the next frame.
- R8: While `rst` is high, `serTrue` is 0, `serInv` is 1 and `wordStrobe` is 0. The first clock edge with `rst` low starts a frame: after that edge the start bit and the strobe are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| patSel | input | 2 | Payload source select |
| wordStrobe | output | 1 | Pulses with each frame's start bit |
| serTrue | output | 1 | Serial bit as framed |
| serInv | output | 1 | Inverse of serTrue |

## Verification
The bench goes after the frame edges. If the shift order were reversed or the framing constants swapped, the fixed patterns would arrive as some other twelve-bit value and not as 101010101010 and 111111000000. If the counter wrapped at 11 or 13, the strobe spacing and the stop-bit position would drift. The bench changes the pattern select in the middle of a frame: a design that forwarded the select combinationally would corrupt the tail of that frame. The bench also asserts reset in the middle of a frame, where wrong idle levels or a late restart would show at once. Random frames are compared with a model of the stated generator polynomial and collector, so a wrong tap, seed or bit order changes the payload values.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int PAYLOAD_W = 10;
  localparam int WORD_W    = PAYLOAD_W + 2;
  localparam int CNT_W     = $clog2(WORD_W);
  localparam int LFSR_W    = 16;

  // patSel codes
  localparam logic [1:0] SEL_ALT = 2'b01;
  localparam logic [1:0] SEL_SQR = 2'b10;

  typedef struct packed {
    logic loadWord;   // capture a new frame this cycle
    logic shiftBit;   // advance the frame by one bit
  } ctrlStrobes_t;

  // 0101...: even bit positions set, so the frame reads 1010...10
  function automatic logic [PAYLOAD_W-1:0] altPayload();
    logic [PAYLOAD_W-1:0] v;
    for (int i = 0; i < PAYLOAD_W; i++) v[i] = (i % 2 == 0);
    return v;
  endfunction

  // upper half ones, lower half zeros
  function automatic logic [PAYLOAD_W-1:0] sqrPayload();
    logic [PAYLOAD_W-1:0] v;
    for (int i = 0; i < PAYLOAD_W; i++) v[i] = (i >= PAYLOAD_W / 2);
    return v;
  endfunction
endpackage

// File: rtl/lfsr_source.sv
module lfsr_source #(
  parameter int          WIDTH = 16,
  parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  output logic newBit
);
  logic [WIDTH-1:0] state;
  logic             feedback;

  assign feedback = ^(state & TAP_MASK);
  assign newBit   = feedback;

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[WIDTH-2:0], feedback};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R5
  AST_LFSR_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state[WIDTH-1:1] == $past(state[WIDTH-2:0])); // R4
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
#(
  parameter int WORD_BITS = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strobes
);
  localparam int CW = $clog2(WORD_BITS);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (rst)                 bitCnt <= '0;
    else if (bitCnt == LAST) bitCnt <= '0;
    else                     bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobes.loadWord = !rst && (bitCnt == '0);
    strobes.shiftBit = !rst && (bitCnt != '0);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= LAST); // R2
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobes.loadWord |=> !strobes.loadWord); // R2
  AST_RESET_CNT: assert property (@(posedge clk)
    rst |=> bitCnt == '0); // R8
endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_pkg::*;
#(
  parameter int PW = PAYLOAD_W,
  parameter int LW = LFSR_W,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  input  logic [1:0]   patSel,
  output logic         wordStrobe,
  output logic         serTrue,
  output logic         serInv
);
  localparam int WW = PW + 2;
  localparam logic [PW-1:0] ALT_P = altPayload();
  localparam logic [PW-1:0] SQR_P = sqrPayload();

  logic          lfsrBit;
  logic [PW-1:0] collector;
  logic [PW-1:0] payload;
  logic [WW-1:0] frame;
  logic [WW-1:0] shiftReg;

  lfsr_source #(.WIDTH(LW), .TAP_MASK(TAPS), .SEED(SEED)) i_lfsr (
    .clk    (clk),
    .rst    (rst),
    .newBit (lfsrBit)
  );

  always_comb begin
    unique case (patSel)
      SEL_ALT: payload = ALT_P;
      SEL_SQR: payload = SQR_P;
      default: payload = collector;
    endcase
    frame = {1'b1, payload, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collector  <= '0;
      shiftReg   <= '0;
      serTrue    <= 1'b0;
      serInv     <= 1'b1;
      wordStrobe <= 1'b0;
    end else begin
      collector  <= {collector[PW-2:0], lfsrBit};
      wordStrobe <= strobes.loadWord;
      if (strobes.loadWord) begin
        shiftReg <= {frame[WW-2:0], 1'b0};
        serTrue  <= frame[WW-1];
        serInv   <= ~frame[WW-1];
      end else if (strobes.shiftBit) begin
        shiftReg <= {shiftReg[WW-2:0], 1'b0};
        serTrue  <= shiftReg[WW-1];
        serInv   <= ~shiftReg[WW-1];
      end
    end
  end

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    serInv == !serTrue); // R6
  AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
    wordStrobe |-> serTrue); // R1
  AST_STOP_BIT: assert property (@(posedge clk) disable iff (rst)
    strobes.loadWord |-> !serTrue); // R1
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!serTrue && serInv && !wordStrobe)); // R8
endmodule

// File: rtl/frame_serializer_top.sv
module frame_serializer_top
  import frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] patSel,
  output logic       wordStrobe,
  output logic       serTrue,
  output logic       serInv
);
  ctrlStrobes_t strobes;

  frame_ctrl #(.WORD_BITS(WORD_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  frame_datapath #(.PW(PAYLOAD_W), .LW(LFSR_W)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .patSel     (patSel),
    .wordStrobe (wordStrobe),
    .serTrue    (serTrue),
    .serInv     (serInv)
  );
endmodule

// File: tb/test_frame_serializer_top.sv
module test_frame_serializer_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] patSel = 2'b00;
  logic       wordStrobe, serTrue, serInv;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  frame_serializer_top i_frame_serializer_top (
    .clk(clk), .rst(rst), .patSel(patSel),
    .wordStrobe(wordStrobe), .serTrue(serTrue), .serInv(serInv)
  );

  // Reference model built from R3/R4 only
  logic [15:0] mLfsr;
  logic [9:0]  mCol;
  int          mCnt;
  logic [11:0] mExp;
  logic        mFb;
  assign mFb = mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10];

  always @(posedge clk) begin
    if (rst) begin
      mLfsr <= 16'hACE1; mCol <= '0; mCnt <= 0;
    end else begin
      if (mCnt == 0) begin
        case (patSel)
          2'b01:   mExp <= 12'b101010101010;
          2'b10:   mExp <= 12'b111111000000;
          default: mExp <= {1'b1, mCol, 1'b0};
        endcase
      end
      mCnt  <= (mCnt == 11) ? 0 : mCnt + 1;
      mLfsr <= {mLfsr[14:0], mFb};
      mCol  <= {mCol[8:0], mFb};
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; waits for a strobe and gathers one frame.
  task automatic recvWord(output logic [11:0] w, output logic [11:0] e,
                          input int switchAt, input logic [1:0] newSel);
    int guard = 0;
    bit cmpOk = 1;
    bit strbOk = 1;
    while (!wordStrobe && guard < 40) begin
      @(negedge clk); guard++;
    end
    check(guard < 40, "R2 strobe seen", guard, 0);
    e = mExp;
    for (int i = 0; i < 12; i++) begin
      w[11 - i] = serTrue;
      if (serInv !== ~serTrue) cmpOk = 0;
      if (wordStrobe !== (i == 0)) strbOk = 0;
      if (i == switchAt) patSel = newSel;
      if (i < 11) @(negedge clk);
    end
    check(cmpOk, "R6 complement", 0, 1);
    check(strbOk, "R2 strobe only on start bit", 0, 1);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    @(negedge clk);
    check(serTrue == 0 && serInv == 1 && wordStrobe == 0, "R8 idle in reset",
          {serTrue, serInv, wordStrobe}, 3'b010);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(wordStrobe == 1 && serTrue == 1, "R8 first frame after release",
          {wordStrobe, serTrue}, 2'b11);
  endtask

  task automatic testAlternating();
    logic [11:0] w, e;
    patSel = 2'b01;
    recvWord(w, e, -1, 2'b01);   // may still carry the previous selection
    recvWord(w, e, -1, 2'b01);
    check(w == 12'b101010101010, "R3 alternating frame", w, 12'b101010101010);
    check(w[11] == 1 && w[0] == 0, "R1 start/stop bits", w, 12'b100000000000);
  endtask

  task automatic testSquare();
    logic [11:0] w, e;
    patSel = 2'b10;
    recvWord(w, e, -1, 2'b10);
    recvWord(w, e, -1, 2'b10);
    check(w == 12'b111111000000, "R3 square frame", w, 12'b111111000000);
    check(w[10:1] == 10'b1111100000, "R1 payload msb first", w[10:1], 10'b1111100000);
  endtask

  task automatic testRandom();
    logic [11:0] w, e, first;
    bit differs = 0;
    patSel = 2'b00;
    recvWord(w, e, -1, 2'b00);
    for (int k = 0; k < 6; k++) begin
      patSel = (k % 2 == 0) ? 2'b00 : 2'b11;
      recvWord(w, e, -1, patSel);
      if (k == 0) first = w;
      else if (w != first) differs = 1;
      check(w == e, "R4 random frame", w, e);
    end
    check(differs, "R4 payload varies", 0, 1);
  endtask

  task automatic testSpacing();
    logic [11:0] w, e;
    recvWord(w, e, -1, patSel);
    @(negedge clk);
    check(wordStrobe == 1, "R2 strobe 12 cycles later", wordStrobe, 1);
    check(serTrue == 1, "R1 stop followed by start", serTrue, 1);
  endtask

  task automatic testMidSwitch();
    logic [11:0] w, e;
    patSel = 2'b01;
    recvWord(w, e, -1, 2'b01);
    recvWord(w, e, 4, 2'b10);
    check(w == 12'b101010101010, "R7 frame unchanged by mid-frame select",
          w, 12'b101010101010);
    @(negedge clk);
    recvWord(w, e, -1, 2'b10);
    check(w == 12'b111111000000, "R7 new select in next frame", w, 12'b111111000000);
  endtask

  task automatic testMidReset();
    logic [11:0] w, e;
    patSel = 2'b00;
    repeat (5) @(negedge clk);
    doReset();
    recvWord(w, e, -1, 2'b00);
    check(w == 12'b100000000000, "R4 first random frame after reset is cleared collector",
          w, 12'b100000000000);
    recvWord(w, e, -1, 2'b00);
    check(w == e, "R4 second random frame after reset", w, e);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(serTrue == 0 && serInv == 1 && wordStrobe == 0, "R8 reset state",
          {serTrue, serInv, wordStrobe}, 3'b010);
    doReset();
    testRandom();
    testAlternating();
    testSquare();
    testSpacing();
    testMidSwitch();
    testMidReset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule